// File: doc/BRIEF.md
# Shared-Line Serial Flash Read Engine

This block fetches a run of 32-bit words from a serial NOR flash whose data input and data output are joined on a single bidirectional wire. A host pulses a start strobe with a 24-bit byte address and a nonzero word count. The engine then lowers chip select and sends the fast-read opcode and the address over the shared wire. It releases the wire during the eight dummy clocks and shifts in the requested words, raising a one-cycle valid strobe for each one.

The pin side uses three outputs and one input: an active-low select, a serial clock in SPI mode 0 (idle low), the data value, and the data output-enable. The shared wire is read back on the input. The serial clock runs at the system clock divided by an even parameter of at least 4. The master changes its output-enable only while the serial clock is low, and drops it half a serial period before the first dummy rising edge. The flash first drives the wire after the falling edge that ends the dummy byte, so the two drivers never overlap.

Top module: `hdx_flash_reader`

## Requirements
- R1: Out of reset csN is 1, sclk is 0, dqOe is 0, busy is 0 and rdValid is 0.
- R2: A start strobe seen while idle with a nonzero wordCount is accepted at that clock edge. busy is 1 from that edge, csN falls one cycle later, and busy stays 1 on every cycle in which csN is 0.
- R3: A start strobe with wordCount equal to 0 is ignored: busy, csN and dqOe keep their idle values. A start strobe that arrives while busy is 1 is also ignored and does not change the running transfer.
- R4: While dqOe is 1, the engine sends opcode 0x0B and then the 24-bit address, all MSB first, one bit per sclk period. Every bit is stable at its sclk rising edge.
- R5: During a transfer, sclk rising edges are CLK_DIV system cycles apart, each high time lasts CLK_DIV/2 cycles, and sclk is 0 whenever csN is 1.
- R6: dqOe is 1 at all 32 header rising edges and 0 from before the first dummy rising edge until csN returns to 1. dqOe is never 1 while csN is 1, and it is never 1 while the flash drives the wire.
- R7: After 8 dummy clocks the engine samples the wire at each sclk rising edge. Bits are gathered MSB first into bytes, and each word holds its first byte in bits 7:0 and its fourth byte in bits 31:24.
- R8: Exactly wordCount words are delivered, each with a one-cycle rdValid pulse. Word k (counting from 0) appears CLK_DIV*(72+32k)+CLK_DIV/2+1 cycles after the accepting edge.
- R9: csN returns to 1 exactly CLK_DIV*(42+32*wordCount)+1 cycles after the accepting edge, with sclk 0 at both chip-select edges, after 40+32*wordCount rising edges of sclk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to begin a read |
| startAddr | input | 24 | Byte address of the first word |
| wordCount | input | CNT_W | Number of 32-bit words to read; 0 means no transfer |
| rdData | output | 32 | Assembled read word |
| rdValid | output | 1 | One-cycle strobe marking rdData as new |
| busy | output | 1 | High from acceptance until chip select is released |
| csN | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| dqOut | output | 1 | Value driven onto the shared data wire |
| dqOe | output | 1 | Output-enable for the shared data wire |
| dqIn | input | 1 | Level read back from the shared data wire |

## Verification
Each result has a fixed cycle offset from the accepting edge. busy is due at offset 0, the falling chip select at 1, word k at CLK_DIV*(72+32k)+CLK_DIV/2+1, and the rising chip select at CLK_DIV*(42+32N)+1. The bench stamps the accepting edge with a cycle counter and records the counter value at each rdValid and at the chip-select rise. All samples are taken on falling system-clock edges, and the recorded stamps are compared with these formulas. A behavioural flash on the shared wire counts serial edges, records the opcode and address it receives, and notes any cycle in which both sides drive the wire.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  localparam int OPCODE_W = 8;
  localparam logic [OPCODE_W-1:0] FAST_READ_OP = 8'h0B;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int DUMMY_W = 8;
  localparam int HDR_W = OPCODE_W + ADDR_W;
  localparam int BIT_W = $clog2((HDR_W > WORD_W) ? HDR_W : WORD_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XMIT,
    ST_TURN,
    ST_RECV,
    ST_TAIL
  } hdxState_t;

  // per-cycle commands from control to datapath; datapath registers them
  typedef struct packed {
    logic busy;
    logic load;
    logic csLow;
    logic oe;
    logic sclkHigh;
    logic shiftTx;
    logic sample;
    logic byteEnd;
    logic wordEnd;
  } hdxStrobe_t;
endpackage

// File: rtl/hdx_ctrl.sv
module hdx_ctrl
  import hdx_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] wordCount,
  output hdxStrobe_t       strobe
);
  localparam int PH_W = $clog2(CLK_DIV);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(CLK_DIV / 2);
  localparam logic [BIT_W-1:0] HDR_LAST = BIT_W'(HDR_W - 1);
  localparam logic [BIT_W-1:0] DUMMY_LAST = BIT_W'(DUMMY_W - 1);
  localparam logic [BIT_W-1:0] WORD_LAST = BIT_W'(WORD_W - 1);
  localparam int BYTE_IDX_W = $clog2(BYTE_W);
  localparam logic [BYTE_IDX_W-1:0] BYTE_LAST = BYTE_IDX_W'(BYTE_W - 1);

  hdxState_t state, stateNext;
  logic [PH_W-1:0] phase;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic [CNT_W-1:0] wordsLeft, wordsNext;
  logic lastPh, accept, atWordEnd;

  assign lastPh = (phase == PH_LAST);
  assign accept = (state == ST_IDLE) && startReq && (wordCount != '0);
  assign atWordEnd = (bitCnt == WORD_LAST);

  always_comb begin
    strobe = '0;
    stateNext = state;
    bitNext = bitCnt;
    wordsNext = wordsLeft;
    unique case (state)
      ST_IDLE: begin
        strobe.busy = accept;
        strobe.load = accept;
        if (accept) begin
          stateNext = ST_LEAD;
          wordsNext = wordCount;
          bitNext = '0;
        end
      end
      ST_LEAD: begin
        strobe.busy = 1'b1;
        strobe.csLow = 1'b1;
        strobe.oe = 1'b1;
        if (lastPh) stateNext = ST_XMIT;
      end
      ST_XMIT: begin
        strobe.busy = 1'b1;
        strobe.csLow = 1'b1;
        strobe.oe = 1'b1;
        strobe.sclkHigh = (phase >= PH_HALF);
        strobe.shiftTx = lastPh;
        if (lastPh) begin
          if (bitCnt == HDR_LAST) begin
            bitNext = '0;
            stateNext = ST_TURN;
          end else begin
            bitNext = bitCnt + 1'b1;
          end
        end
      end
      ST_TURN: begin
        strobe.busy = 1'b1;
        strobe.csLow = 1'b1;
        strobe.sclkHigh = (phase >= PH_HALF);
        if (lastPh) begin
          if (bitCnt == DUMMY_LAST) begin
            bitNext = '0;
            stateNext = ST_RECV;
          end else begin
            bitNext = bitCnt + 1'b1;
          end
        end
      end
      ST_RECV: begin
        strobe.busy = 1'b1;
        strobe.csLow = 1'b1;
        strobe.sclkHigh = (phase >= PH_HALF);
        strobe.sample = (phase == PH_HALF);
        strobe.byteEnd = (bitCnt[BYTE_IDX_W-1:0] == BYTE_LAST);
        strobe.wordEnd = atWordEnd;
        if (lastPh) begin
          if (atWordEnd) begin
            bitNext = '0;
            if (wordsLeft == CNT_W'(1)) stateNext = ST_TAIL;
            else wordsNext = wordsLeft - 1'b1;
          end else begin
            bitNext = bitCnt + 1'b1;
          end
        end
      end
      ST_TAIL: begin
        strobe.busy = 1'b1;
        strobe.csLow = 1'b1;
        if (lastPh) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
      bitCnt <= '0;
      wordsLeft <= '0;
    end else begin
      state <= stateNext;
      bitCnt <= bitNext;
      wordsLeft <= wordsNext;
      if (state == ST_IDLE || lastPh) phase <= '0;
      else phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/hdx_dpath.sv
module hdx_dpath
  import hdx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hdxStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              dqIn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              busy,
  output logic              csN,
  output logic              sclk,
  output logic              dqOut,
  output logic              dqOe
);
  logic [HDR_W-1:0] txSh;
  logic [BYTE_W-1:0] byteSh, nextByte;
  logic [WORD_W-1:0] wordSh, nextWord;

  assign nextByte = {byteSh[BYTE_W-2:0], dqIn};
  assign nextWord = {nextByte, wordSh[WORD_W-1:BYTE_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
      byteSh <= '0;
      wordSh <= '0;
      rdData <= '0;
      rdValid <= 1'b0;
      busy <= 1'b0;
      csN <= 1'b1;
      sclk <= 1'b0;
      dqOut <= 1'b0;
      dqOe <= 1'b0;
    end else begin
      if (strobe.load) txSh <= {FAST_READ_OP, startAddr};
      else if (strobe.shiftTx) txSh <= {txSh[HDR_W-2:0], 1'b0};
      busy <= strobe.busy;
      csN <= !strobe.csLow;
      sclk <= strobe.sclkHigh;
      dqOe <= strobe.oe;
      dqOut <= strobe.oe ? txSh[HDR_W-1] : 1'b0;
      rdValid <= strobe.sample && strobe.wordEnd;
      if (strobe.sample) begin
        byteSh <= nextByte;
        if (strobe.byteEnd) wordSh <= nextWord;
        if (strobe.wordEnd) rdData <= nextWord;
      end
    end
  end
endmodule

// File: rtl/hdx_flash_reader.sv
module hdx_flash_reader
  import hdx_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              busy,
  output logic              csN,
  output logic              sclk,
  output logic              dqOut,
  output logic              dqOe,
  input  logic              dqIn
);
  hdxStrobe_t strobe;

  hdx_ctrl #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordCount(wordCount),
    .strobe(strobe)
  );

  hdx_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .dqIn(dqIn), .rdData(rdData), .rdValid(rdValid), .busy(busy),
    .csN(csN), .sclk(sclk), .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: rtl/hdx_flash_reader_chk.sv
module hdx_flash_reader_chk (
  input logic clk,
  input logic rstN,
  input logic rdValid,
  input logic busy,
  input logic csN,
  input logic sclk,
  input logic dqOe
);
  assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  assert_oe_only_in_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !csN);

  assert_oe_stays_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && !$past(dqOe)) |-> !dqOe);

  assert_sclk_only_in_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  assert_sclk_high_min_two_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |=> sclk);

  assert_cs_edges_clock_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(csN) || $fell(csN)) |-> (!sclk && !$past(sclk)));

  assert_valid_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  assert_valid_inside_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (busy && !csN));
endmodule

bind hdx_flash_reader hdx_flash_reader_chk uChk (
  .clk(clk), .rstN(rstN), .rdValid(rdValid), .busy(busy),
  .csN(csN), .sclk(sclk), .dqOe(dqOe)
);

// File: tb/sim_hdx_flash_reader.sv
module sim_hdx_flash_reader;
  localparam int DIV = 4;
  localparam int HALF = DIV / 2;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [23:0] startAddr = '0;
  logic [CNT_W-1:0] wordCount = '0;
  logic [31:0] rdData;
  logic rdValid, busy, csN, sclk, dqOut, dqOe;
  logic flashDrive = 1'b0;
  logic flashBit = 1'b0;
  wire dqLine = dqOe ? dqOut : (flashDrive ? flashBit : 1'b1);

  always #5 clk = ~clk;

  hdx_flash_reader #(.CLK_DIV(DIV), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .wordCount(wordCount), .rdData(rdData), .rdValid(rdValid), .busy(busy),
    .csN(csN), .sclk(sclk), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqLine)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t0 = 0;
  bit timedOut = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ (a[23:16] + 8'd101);
  endfunction

  function automatic logic [31:0] expWord(input logic [23:0] a, input int k);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = memByte(a + 24'(4*k + i));
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural flash on the shared wire
  int rc = 0;
  int lastRc = 0;
  int oeBad = 0;
  logic [31:0] hdrSh = '0;
  logic [7:0] capOp = '0;
  logic [23:0] capAddr = '0;
  always @(posedge sclk or negedge sclk or posedge csN) begin
    int di;
    logic [7:0] fb;
    if (csN) begin
      lastRc = rc;
      rc = 0;
      flashDrive = 1'b0;
    end else if (sclk) begin
      if (rc < 32) begin
        hdrSh = {hdrSh[30:0], dqLine};
        if (!dqOe) oeBad++;
      end else if (dqOe) begin
        oeBad++;
      end
      rc++;
      if (rc == 32) begin
        capOp = hdrSh[31:24];
        capAddr = hdrSh[23:0];
      end
    end else if (rc >= 40) begin
      di = rc - 40;
      fb = memByte(capAddr + 24'(di / 8));
      flashBit = fb[7 - (di % 8)];
      flashDrive = 1'b1;
    end
  end

  // pin monitor, sampled on falling system edges
  logic prevCs = 1'b1;
  logic prevSclk = 1'b0;
  int lastRise = 0;
  bit haveRise = 1'b0;
  int wordIdx = 0;
  logic [31:0] gotWord [8];
  int gotLat [8];
  int contention = 0;
  int sclkBad = 0;
  int csEdgeBad = 0;
  int busyBad = 0;
  int csRiseCyc = -1;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevCs && !csN) begin
        wordIdx = 0;
        haveRise = 1'b0;
      end
      if (prevCs != csN && (sclk || prevSclk)) csEdgeBad++;
      if (!prevCs && csN) csRiseCyc = cyc;
      if (!csN && !busy) busyBad++;
      if (csN && sclk) sclkBad++;
      if (dqOe && flashDrive) contention++;
      if (!prevSclk && sclk) begin
        if (haveRise && (cyc - lastRise) != DIV) sclkBad++;
        haveRise = 1'b1;
        lastRise = cyc;
      end
      if (prevSclk && !sclk && (cyc - lastRise) != HALF) sclkBad++;
      if (rdValid) begin
        if (wordIdx < 8) begin
          gotWord[wordIdx] = rdData;
          gotLat[wordIdx] = cyc - t0;
        end
        wordIdx++;
      end
    end
    prevCs = csN;
    prevSclk = sclk;
  end

  task automatic checkIdle(input string tag);
    chk(csN == 1'b1, {tag, " csN"}, csN, 1);
    chk(sclk == 1'b0 && dqOe == 1'b0, {tag, " sclk/dqOe"}, {sclk, dqOe}, 0);
    chk(busy == 1'b0 && rdValid == 1'b0, {tag, " busy/rdValid"}, {busy, rdValid}, 0);
  endtask

  task automatic runTxn(input logic [23:0] addr, input int n, input bit extra);
    int c0 = contention, o0 = oeBad, s0 = sclkBad, e0 = csEdgeBad, b0 = busyBad;
    int guard = 0;
    int expCs;
    @(negedge clk);
    startAddr = addr;
    wordCount = CNT_W'(n);
    startReq = 1'b1;
    @(negedge clk);
    t0 = cyc;
    startReq = 1'b0;
    chk(busy == 1'b1, "R2 busy at accepting edge", busy, 1);
    chk(csN == 1'b1, "R2 csN falls one cycle later", csN, 1);
    if (extra) begin
      repeat (60) @(negedge clk);
      startAddr = ~addr;
      wordCount = CNT_W'(n + 1);
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (csRiseCyc <= t0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
    expCs = DIV * (42 + 32 * n) + 1;
    if (extra) chk(wordIdx == n, "R3 strobe while busy ignored", wordIdx, n);
    else chk(wordIdx == n, "R8 word count", wordIdx, n);
    for (int k = 0; k < n && k < 8; k++) begin
      chk(gotWord[k] == expWord(addr, k), "R7 word data", gotWord[k], expWord(addr, k));
      chk(gotLat[k] == DIV * (72 + 32 * k) + HALF + 1, "R8 word latency",
          gotLat[k], DIV * (72 + 32 * k) + HALF + 1);
    end
    chk(capOp == 8'h0B, "R4 opcode", capOp, 8'h0B);
    chk(capAddr == addr, "R4 address", capAddr, addr);
    chk(csRiseCyc - t0 == expCs, "R9 csN rise cycle", csRiseCyc - t0, expCs);
    chk(lastRc == 40 + 32 * n, "R9 sclk rising edges", lastRc, 40 + 32 * n);
    chk(oeBad == o0, "R6 dqOe at sclk edges", oeBad - o0, 0);
    chk(contention == c0, "R6 no contention", contention - c0, 0);
    chk(sclkBad == s0, "R5 sclk period and width", sclkBad - s0, 0);
    chk(csEdgeBad == e0, "R9 sclk low at csN edges", csEdgeBad - e0, 0);
    chk(busyBad == b0, "R2 busy through frame", busyBad - b0, 0);
    chk(busy == 1'b0, "R2 busy released", busy, 0);
  endtask

  initial begin
    logic [23:0] addrs [4] = '{24'h000000, 24'h123456, 24'hFFFFFE, 24'h80A5C3};
    fork
      begin
        repeat (3) @(negedge clk);
        checkIdle("R1 in reset");
        rstN = 1'b1;
        repeat (2) @(negedge clk);
        checkIdle("R1 after reset");
        // R3 zero word count
        begin
          int bad = 0;
          startAddr = 24'h00ABCD;
          wordCount = '0;
          startReq = 1'b1;
          @(negedge clk);
          startReq = 1'b0;
          repeat (30) begin
            if (busy || !csN || dqOe || sclk) bad++;
            @(negedge clk);
          end
          chk(bad == 0, "R3 zero count ignored", bad, 0);
        end
        for (int a = 0; a < 4; a++)
          for (int n = 1; n <= 4; n++)
            runTxn(addrs[a], n, 1'b0);
        runTxn(24'h3C3C3C, 2, 1'b1);
        runTxn(24'h000007, 1, 1'b0);
      end
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    if (timedOut) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule